// File: doc/BRIEF.md
# Vectored Core-Local Interrupt Arbiter

This block gathers a vector of raw interrupt lines and presents one vectored request to a processor core: a valid flag, the number of the winning source and that source's priority. Every source has a small group of memory-mapped registers: an enable bit, a pending bit, an 8-bit priority and a trigger attribute. Software programs these registers over a simple single-cycle write/read bus. A global threshold register sits above the last group.

Raw lines pass through a two-flop synchroniser. An edge-mode source latches a rising edge into its pending bit. The bit stays set until software clears it, or until the core claims that source through the output handshake. A level-mode source shows its synchronised line as its pending state. The arbiter looks at every enabled, pending source whose priority is above the threshold and picks the largest priority. On a tie, the lowest number wins. The result passes through one register stage before it reaches the outputs.

The output is a valid/ready pair with the ID and priority as payload. The offer is re-evaluated every cycle and is not held under back-pressure. While `irq_ready` is low, nothing is consumed, and the offer may change to a more urgent source or drop away. A cycle with `irq_valid` and `irq_ready` both high claims the ID shown in that cycle.

Top module: `clic_arbiter`

## Requirements
- R1: The register group of source n starts at byte address 16·n. The enable register is at +0x0, pending at +0x4, priority at +0x8 and attribute at +0xC. The threshold register is at 16·NUM_SRC. Any other address reads 0. The enable register holds bit 0 of the last write and reads it back.
- R2: The priority and threshold registers hold bits 7:0 of a write and read back that value zero-extended. The attribute register holds bit 0 and reads back 0 or 1.
- R3: Attribute bit 0 = 1 selects edge mode. In that mode a rising edge of the line, after the two-flop synchroniser, sets the pending bit. The bit stays set after the line falls.
- R4: In edge mode, writing the pending register loads bit 0 of the write, so 1 sets the bit and 0 clears it. In level mode, a write to the pending register has no effect.
- R5: In level mode (attribute bit 0 = 0), the pending register reads the synchronised line.
- R6: A source is eligible only when it is enabled, pending, and its priority is strictly greater than the threshold.
- R7: Among eligible sources the largest priority wins. Among equal priorities the lowest source number wins.
- R8: The outputs `irq_valid`, `irq_id` and `irq_prio` are registered. When no source is eligible, all three are 0.
- R9: A cycle with `irq_valid` and `irq_ready` both high clears the pending bit of the presented source if it is in edge mode. A level-mode source is not affected.
- R10: When a synchronised rising edge arrives in the same cycle as a pending clear, whether from a claim or from a software write of 0, the pending bit ends up set.
- R11: After reset, every register reads 0 and `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_in | input | NUM_SRC | Raw interrupt lines, asynchronous |
| irq_valid | output | 1 | A vectored request is offered |
| irq_ready | input | 1 | Core accepts (claims) the offered source |
| irq_id | output | ID_W | Number of the offered source |
| irq_prio | output | PRIO_W | Priority of the offered source |

## Verification
The pending bit of an edge source can be set by a new synchronised rising edge in the same cycle that a claim handshake or a software write of 0 clears it. The bench counts the register stages from a line change to the pending update and raises the line exactly two clock edges before the claim or the clearing write. It then reads the pending register back and expects 1. A separate run with only the claim expects 0, which shows that the clear path itself works.

// File: rtl/clic_pkg.sv
package clic_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    FLD_ENABLE = 2'd0,
    FLD_PEND   = 2'd1,
    FLD_PRIO   = 2'd2,
    FLD_ATTR   = 2'd3
  } fld_e;
endpackage

// File: rtl/clic_sync.sv
module clic_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/clic_src.sv
module clic_src
  import clic_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_grp,
  input  fld_e              wr_fld,
  input  logic [PRIO_W-1:0] wdata,
  input  logic              line_sync,
  input  logic              claim_hit,
  output logic              en_o,
  output logic              pend_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              edge_o
);
  logic              en_q, edge_q, pend_q, prev_q;
  logic [PRIO_W-1:0] prio_q;
  logic              rise, pend_d, pend_wr, attr_wr;

  assign rise    = line_sync & ~prev_q;
  assign pend_wr = wr_grp && (wr_fld == FLD_PEND);
  assign attr_wr = wr_grp && (wr_fld == FLD_ATTR);

  always_comb begin
    pend_d = pend_q;
    if (!edge_q) begin
      pend_d = 1'b0;
    end else begin
      if (pend_wr)   pend_d = wdata[0];
      if (claim_hit) pend_d = 1'b0;
      if (rise)      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
      prio_q <= '0;
    end else begin
      prev_q <= line_sync;
      pend_q <= pend_d;
      if (wr_grp && wr_fld == FLD_ENABLE) en_q   <= wdata[0];
      if (wr_grp && wr_fld == FLD_PRIO)   prio_q <= wdata;
      if (attr_wr)                        edge_q <= wdata[0];
    end
  end

  assign en_o   = en_q;
  assign edge_o = edge_q;
  assign prio_o = prio_q;
  assign pend_o = edge_q ? pend_q : line_sync;

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && pend_q && !pend_wr && !attr_wr && !claim_hit) |=> pend_q); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && rise && !attr_wr) |=> pend_q); // R10
  AST_CLAIM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && claim_hit && !rise && !wr_grp) |=> !pend_q); // R9
endmodule

// File: rtl/clic_select.sv
module clic_select #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC-1:0]             en,
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              thresh,
  output logic                           sel_valid,
  output logic [ID_W-1:0]                sel_id,
  output logic [PRIO_W-1:0]              sel_prio
);
  logic [NUM_SRC-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_cand
      assign cand[g] = en[g] & pend[g] & (prio[g] > thresh);
    end
  endgenerate

  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    sel_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!sel_valid || prio[i] > sel_prio)) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(i);
        sel_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/clic_arbiter.sv
module clic_arbiter
  import clic_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRIO_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = $clog2(NUM_SRC),
  parameter int ADDR_W      = $clog2(NUM_SRC * 16 + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [ID_W-1:0]    irq_id,
  output logic [PRIO_W-1:0]  irq_prio
);
  localparam int GRP_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(NUM_SRC * 16);

  logic [NUM_SRC-1:0]             line_sync, en_v, pend_v, edge_v, grp_hit;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
  logic [PRIO_W-1:0]              thr_q;
  logic                           thr_hit, sel_valid;
  logic [ID_W-1:0]                sel_id;
  logic [PRIO_W-1:0]              sel_prio;
  logic [GRP_W-1:0]               grp;
  fld_e                           fld;
  logic                           unused_bits;

  assign grp         = reg_addr[ADDR_W-1:4];
  assign fld         = fld_e'(reg_addr[3:2]);
  assign thr_hit     = (reg_addr == THR_ADDR);
  assign unused_bits = &{1'b0, reg_wdata[DATA_W-1:PRIO_W], reg_addr[1:0]};

  clic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(irq_in), .d_out(line_sync)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      assign grp_hit[g] = (grp == GRP_W'(g));
      clic_src #(.PRIO_W(PRIO_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_grp   (reg_wr && grp_hit[g]),
        .wr_fld   (fld),
        .wdata    (reg_wdata[PRIO_W-1:0]),
        .line_sync(line_sync[g]),
        .claim_hit(irq_valid && irq_ready && (irq_id == ID_W'(g))),
        .en_o     (en_v[g]),
        .pend_o   (pend_v[g]),
        .prio_o   (prio_v[g]),
        .edge_o   (edge_v[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (reg_wr && thr_hit) thr_q <= reg_wdata[PRIO_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grp_hit[i]) begin
        case (fld)
          FLD_ENABLE: reg_rdata = DATA_W'(en_v[i]);
          FLD_PEND:   reg_rdata = DATA_W'(pend_v[i]);
          FLD_PRIO:   reg_rdata = DATA_W'(prio_v[i]);
          default:    reg_rdata = DATA_W'(edge_v[i]);
        endcase
      end
    end
    if (thr_hit) reg_rdata = DATA_W'(thr_q);
  end

  clic_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
    .en(en_v), .pend(pend_v), .prio(prio_v), .thresh(thr_q),
    .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_prio  <= '0;
    end else begin
      irq_valid <= sel_valid;
      irq_id    <= sel_id;
      irq_prio  <= sel_prio;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_id == '0 && irq_prio == '0)); // R8
  AST_ABOVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_prio > $past(thr_q))); // R6
endmodule

// File: tb/sim_clic_arbiter.sv
`timescale 1ns/1ps
module sim_clic_arbiter;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic        irq_valid, irq_ready = 1'b0;
  logic [2:0]  irq_id;
  logic [7:0]  irq_prio;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  clic_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id),
    .irq_prio(irq_prio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] outv();
    return {irq_valid, 20'd0, irq_id, irq_prio};
  endfunction

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  pr [N];
    logic [7:0]  thr, en, ln, bp;
    logic        bv;
    logic [2:0]  bi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    for (int i = 0; i < N; i++)
      for (int f = 0; f < 4; f++) begin
        rd(8'(i * 16 + f * 4), d);
        chk("R11", d, 0);
      end
    chk("R11 out", outv(), 0);

    // R1 R2: register map sweep
    for (int i = 0; i < N; i++) begin
      wr(8'(i * 16), 32'hFFFF_FFF0 | 32'(i & 1));
      wr(8'(i * 16 + 8), 32'h1200 | 32'(i * 29 + 3));
      wr(8'(i * 16 + 12), 32'hFE | 32'((i >> 1) & 1));
    end
    for (int i = 0; i < N; i++) begin
      rd(8'(i * 16), d);      chk("R1 enable", d, 32'(i & 1));
      rd(8'(i * 16 + 8), d);  chk("R2 prio", d, 32'((i * 29 + 3) & 255));
      rd(8'(i * 16 + 12), d); chk("R2 attr", d, 32'((i >> 1) & 1));
    end
    wr(8'h80, 32'h1A5);
    rd(8'h80, d); chk("R2 thresh", d, 32'hA5);
    rd(8'h84, d); chk("R1 unmapped", d, 0);

    // R5 R6 R7 R8: arbitration sweep, all level mode
    for (int i = 0; i < N; i++) wr(8'(i * 16 + 12), 0);
    for (int t = 0; t < 48; t++) begin
      thr = 8'((t % 5) * 50);
      en  = 8'((t * 29 + 7) * 37);
      ln  = 8'((t * 53 + 11) * 73);
      for (int i = 0; i < N; i++) begin
        pr[i] = 8'(((i * 5 + t * 3) % 4) * 60 + 10);
        wr(8'(i * 16 + 8), 32'(pr[i]));
        wr(8'(i * 16), 32'(en[i]));
      end
      wr(8'h80, 32'(thr));
      irq_in = ln;
      settle();
      bv = 1'b0; bi = '0; bp = '0;
      for (int i = 0; i < N; i++)
        if (en[i] && ln[i] && pr[i] > thr && (!bv || pr[i] > bp)) begin
          bv = 1'b1; bi = 3'(i); bp = pr[i];
        end
      chk("R7 R6 R8 winner", outv(), {bv, 20'd0, bi, bp});
      rd(8'(((t % N)) * 16 + 4), d);
      chk("R5 level pend", d, 32'(ln[t % N]));
    end

    // setup: only source 2 enabled, edge mode
    irq_in = '0;
    for (int i = 0; i < N; i++) wr(8'(i * 16), 0);
    wr(8'h80, 0);
    wr(8'h20, 1); wr(8'h28, 90); wr(8'h2C, 1);
    settle();
    chk("R8 idle", outv(), 0);

    // R3: edge capture holds after line falls
    irq_in[2] = 1'b1; repeat (3) @(negedge clk);
    irq_in[2] = 1'b0; settle();
    rd(8'h24, d); chk("R3 pend latched", d, 1);
    chk("R3 offer", outv(), {1'b1, 20'd0, 3'd2, 8'd90});

    // R9: claim clears edge source
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
    settle();
    rd(8'h24, d); chk("R9 claim clr", d, 0);
    chk("R9 no offer", outv(), 0);

    // R4: software set and clear in edge mode
    wr(8'h24, 1); rd(8'h24, d); chk("R4 sw set", d, 1);
    wr(8'h24, 0); rd(8'h24, d); chk("R4 sw clr", d, 0);

    // R10: rising edge meets claim
    wr(8'h24, 1); settle();
    irq_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
    settle();
    rd(8'h24, d); chk("R10 edge vs claim", d, 1);

    // R10: rising edge meets software clear
    irq_in[2] = 1'b0; settle();
    irq_in[2] = 1'b1;
    @(negedge clk);
    wr(8'h24, 0);
    settle();
    rd(8'h24, d); chk("R10 edge vs sw clr", d, 1);
    irq_in[2] = 1'b0;
    wr(8'h24, 0); wr(8'h20, 0);

    // R9: claim leaves level source untouched; R4: level write ignored
    wr(8'h50, 1); wr(8'h58, 40);
    irq_in[5] = 1'b1; settle();
    chk("R9 level offer", outv(), {1'b1, 20'd0, 3'd5, 8'd40});
    @(negedge clk); irq_ready = 1'b1;
    @(negedge clk); irq_ready = 1'b0;
    settle();
    rd(8'h54, d); chk("R9 level kept", d, 1);
    chk("R9 level still offered", outv(), {1'b1, 20'd0, 3'd5, 8'd40});
    wr(8'h64, 1); rd(8'h64, d); chk("R4 level wr ignored", d, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule